// File: doc/BRIEF.md
# Isochronous IN Zero-Length Responder

This block chooses the reply to every IN token addressed to a high-bandwidth isochronous IN endpoint. A microframe start strobe loads the configured number of packets per microframe. For each IN token the block then sends a single command. The command is either "send the queued data packet" or "send a zero-length packet", and it carries the data PID for the token's place in the microframe. The host therefore always gets a reply, even when the FIFO has no packet ready, and the PID sequence never drifts.

The serial interface engine uses the command to frame the packet, add the CRC and fetch the payload. Packets may be up to 1024 bytes, but the payload never passes through this block. The command output is a one-cycle pulse and cannot be held off: the serial engine must accept it in the cycle it appears. The token, strobe and packet-available inputs are plain level signals, sampled on each rising clock edge.

Top module: `iso_zlp_responder`

## Requirements
- R1: While `rst_n` is low, `rsp_valid`, `rsp_is_data` and `rsp_pid` are all zero.
- R2: An IN token sampled at a clock edge produces exactly one `rsp_valid` pulse, one cycle long, in the following cycle. A cycle with no token produces no pulse. Whenever `rsp_valid` is low, `rsp_is_data` and `rsp_pid` read zero.
- R3: `rsp_pid` uses the encoding DATA0 = 2'b00, DATA1 = 2'b01 and DATA2 = 2'b10. The value 2'b11 never appears with a pulse.
- R4: A microframe strobe with a count of N (1 to 3) makes the first IN token return PID N-1. Each later token in the same microframe returns a PID one level lower, ending at DATA0.
- R5: If `pkt_avail` is high when a token arrives, the reply is a data send (`rsp_is_data` = 1). If it is low, the reply is a zero-length packet (`rsp_is_data` = 0) with the same sequence PID. A zero-length reply uses up its sequence position just as a data reply does.
- R6: After N tokens have been answered in a microframe, every further token gets a zero-length reply with DATA0, whatever the state of `pkt_avail`.
- R7: A strobe restarts the sequence, even in the middle of a sequence. A token sampled in the same cycle as the strobe counts as the first token of the new microframe.
- R8: `cfg_mult` is read only at the strobe. Changing it between strobes has no effect until the next strobe. A count of 0 is treated as 1.
- R9: From reset until the first strobe, every token gets a zero-length reply with DATA0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_start | input | 1 | One-cycle microframe start strobe |
| cfg_mult | input | MULT_W | Packets per microframe (0 is read as 1) |
| in_tok | input | 1 | One-cycle IN token for this endpoint |
| pkt_avail | input | 1 | A full packet is queued in the FIFO |
| rsp_valid | output | 1 | One-cycle response command pulse |
| rsp_is_data | output | 1 | 1 = send data packet, 0 = send zero-length packet |
| rsp_pid | output | 2 | Data PID code (00 DATA0, 01 DATA1, 10 DATA2) |

## Verification
The only state is the count of positions left in the microframe. If that count is wrong, it shows up on `rsp_pid` at the very next token reply. A wrong count also changes the point at which replies switch to forced zero-length DATA0, so that boundary moves by one or more tokens. A strobe that fails to reload the count shows up on the first reply of the new microframe. An off-by-one decrement, or a zero-length reply that does not consume its position, shows up on the second reply. The bench compares every pulse with a reference model driven by the same inputs. It runs sequences with mixed packet availability, strobes in the middle of a sequence, strobes that coincide with a token, and configuration changes between strobes.

// File: rtl/iso_zlp_pkg.sv
package iso_zlp_pkg;
  typedef enum logic [1:0] {
    PID_D0 = 2'b00,
    PID_D1 = 2'b01,
    PID_D2 = 2'b10
  } pid_e;

  typedef struct packed {
    logic is_data;
    pid_e pid;
  } rsp_t;
endpackage

// File: rtl/iso_uf_tracker.sv
// Holds how many sequence positions remain in the current microframe.
module iso_uf_tracker #(
  parameter int MULT_W   = 2,
  parameter int MAX_MULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_start,
  input  logic              in_tok,
  input  logic [MULT_W-1:0] cfg_mult,
  output logic [MULT_W-1:0] rem_now
);
  localparam logic [MULT_W-1:0] ONE  = MULT_W'(1);
  localparam logic [MULT_W-1:0] CEIL = MULT_W'(MAX_MULT);

  logic [MULT_W-1:0] rem_q;
  logic [MULT_W-1:0] eff_cfg;

  // a count of zero is read as one; anything above the ceiling is clipped
  always_comb begin
    if (cfg_mult == '0)        eff_cfg = ONE;
    else if (cfg_mult > CEIL)  eff_cfg = CEIL;
    else                       eff_cfg = cfg_mult;
  end

  // a strobe reloads the count in the same cycle, so a coincident token sees it
  assign rem_now = uframe_start ? eff_cfg : rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        rem_q <= '0;
    else if (in_tok && rem_now != '0)  rem_q <= rem_now - ONE;
    else                               rem_q <= rem_now;
  end
endmodule

// File: rtl/iso_rsp_select.sv
// Maps the remaining-position count and FIFO state to a reply.
module iso_rsp_select
  import iso_zlp_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic [MULT_W-1:0] rem_now,
  input  logic              pkt_avail,
  output rsp_t              sel
);
  logic [MULT_W-1:0] pos;

  assign pos = rem_now - MULT_W'(1);

  always_comb begin
    if (rem_now == '0) begin
      sel.is_data = 1'b0;
      sel.pid     = PID_D0;
    end else begin
      sel.is_data = pkt_avail;
      sel.pid     = pid_e'(pos[1:0]);
    end
  end
endmodule

// File: rtl/iso_zlp_responder.sv
module iso_zlp_responder
  import iso_zlp_pkg::*;
#(
  parameter int MULT_W   = 2,
  parameter int MAX_MULT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uframe_start,
  input  logic [MULT_W-1:0] cfg_mult,
  input  logic              in_tok,
  input  logic              pkt_avail,
  output logic              rsp_valid,
  output logic              rsp_is_data,
  output logic [1:0]        rsp_pid
);
  logic [MULT_W-1:0] rem_now;
  rsp_t              sel;

  iso_uf_tracker #(.MULT_W(MULT_W), .MAX_MULT(MAX_MULT)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .uframe_start (uframe_start),
    .in_tok       (in_tok),
    .cfg_mult     (cfg_mult),
    .rem_now      (rem_now)
  );

  iso_rsp_select #(.MULT_W(MULT_W)) u_sel (
    .rem_now   (rem_now),
    .pkt_avail (pkt_avail),
    .sel       (sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_is_data <= 1'b0;
      rsp_pid     <= 2'b00;
    end else begin
      rsp_valid <= in_tok;
      if (in_tok) begin
        rsp_is_data <= sel.is_data;
        rsp_pid     <= sel.pid;
      end else begin
        rsp_is_data <= 1'b0;
        rsp_pid     <= 2'b00;
      end
    end
  end
endmodule

// File: rtl/iso_zlp_responder_chk.sv
module iso_zlp_responder_chk #(
  parameter int MULT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uframe_start,
  input logic [MULT_W-1:0] cfg_mult,
  input logic              in_tok,
  input logic              pkt_avail,
  input logic              rsp_valid,
  input logic              rsp_is_data,
  input logic [1:0]        rsp_pid
);
  assert_pid_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_pid != 2'b11);

  assert_tok_gets_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok |=> rsp_valid);

  assert_pulse_has_tok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tok |=> !rsp_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_is_data && rsp_pid == 2'b00));

  assert_empty_fifo_zlp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && !pkt_avail) |=> !rsp_is_data);

  assert_strobe_first_pid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok && uframe_start && cfg_mult == MULT_W'(3)) |=> rsp_pid == 2'b10);
endmodule

bind iso_zlp_responder iso_zlp_responder_chk #(.MULT_W(MULT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .uframe_start (uframe_start),
  .cfg_mult     (cfg_mult),
  .in_tok       (in_tok),
  .pkt_avail    (pkt_avail),
  .rsp_valid    (rsp_valid),
  .rsp_is_data  (rsp_is_data),
  .rsp_pid      (rsp_pid)
);

// File: tb/iso_zlp_responder_tb_top.sv
`timescale 1ns/1ps
module iso_zlp_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       uframe_start = 1'b0;
  logic [1:0] cfg_mult = 2'd0;
  logic       in_tok = 1'b0;
  logic       pkt_avail = 1'b0;
  logic       rsp_valid;
  logic       rsp_is_data;
  logic [1:0] rsp_pid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference model state
  int m_rem = 0;

  always #2.5 clk = ~clk;

  iso_zlp_responder dut_i (
    .clk(clk), .rst_n(rst_n), .uframe_start(uframe_start), .cfg_mult(cfg_mult),
    .in_tok(in_tok), .pkt_avail(pkt_avail), .rsp_valid(rsp_valid),
    .rsp_is_data(rsp_is_data), .rsp_pid(rsp_pid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus; pushes the expected reply for a token
  task automatic tick(input bit tok, input bit strobe, input int cfg,
                      input bit avail, input string tag);
    @(posedge clk); #1;
    in_tok       = tok;
    uframe_start = strobe;
    cfg_mult     = 2'(cfg);
    pkt_avail    = avail;
    if (strobe) m_rem = (cfg == 0) ? 1 : cfg;
    if (tok) begin
      if (m_rem > 0) begin
        exp_q.push_back({avail, 2'(m_rem - 1)});
        m_rem--;
      end else begin
        exp_q.push_back(3'b000);
      end
      tag_q.push_back(tag);
    end
  endtask

  // monitor: compares every pulse with the queue head
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected pulse", 1, 0);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_is_data, rsp_pid} == e, t, "{is_data,pid}",
                {rsp_is_data, rsp_pid}, e);
        end
      end else begin
        check(!rsp_is_data && rsp_pid == 2'b00, "R2", "idle outputs",
              {rsp_is_data, rsp_pid}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, with a token applied during reset
    in_tok = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(rsp_is_data == 1'b0, "R1", "rsp_is_data in reset", rsp_is_data, 0);
    check(rsp_pid == 2'b00, "R1", "rsp_pid in reset", rsp_pid, 0);
    in_tok = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R9: before any strobe, tokens get zero-length DATA0
    tick(1, 0, 3, 1, "R9");
    tick(1, 0, 3, 1, "R9");
    tick(0, 0, 3, 0, "R2");

    // R4/R5: count 3, all packets ready: DATA2, DATA1, DATA0 with data
    tick(0, 1, 3, 0, "R4");
    tick(1, 0, 3, 1, "R4");
    tick(1, 0, 3, 1, "R4");
    tick(1, 0, 3, 1, "R4");
    // R6: count exhausted, packet ready but ZLP DATA0
    tick(1, 0, 3, 1, "R6");
    tick(1, 0, 3, 1, "R6");

    // R7: token coincides with strobe, count 2; R5: ZLP keeps the PID and consumes it
    tick(1, 1, 2, 0, "R7");
    tick(1, 0, 2, 1, "R5");
    tick(1, 0, 2, 1, "R6");

    // R5: mixed availability under count 3
    tick(0, 1, 3, 0, "R5");
    tick(1, 0, 3, 1, "R5");
    tick(0, 0, 3, 0, "R2");
    tick(1, 0, 3, 0, "R5");
    tick(1, 0, 3, 1, "R5");

    // R7: strobe in the middle of a sequence restarts at DATA2
    tick(0, 1, 3, 0, "R7");
    tick(1, 0, 3, 1, "R7");
    tick(0, 1, 3, 0, "R7");
    tick(1, 0, 3, 1, "R7");
    tick(1, 0, 3, 0, "R7");

    // R8: count 1 captured, later change to 3 ignored until next strobe
    tick(0, 1, 1, 0, "R8");
    tick(1, 0, 3, 1, "R8");
    tick(1, 0, 3, 1, "R8");
    tick(0, 1, 3, 0, "R8");
    tick(1, 0, 3, 1, "R8");

    // R8: count 0 behaves as 1
    tick(1, 1, 0, 1, "R8");
    tick(1, 0, 0, 1, "R8");

    // R4: count 2 from a separate strobe, all ZLP
    tick(0, 1, 2, 0, "R4");
    tick(1, 0, 2, 0, "R4");
    tick(1, 0, 2, 0, "R4");
    tick(1, 0, 2, 0, "R6");

    tick(0, 0, 0, 0, "R2");
    tick(0, 0, 0, 0, "R2");
    @(negedge clk);
    check(exp_q.size() == 0, "R2", "replies missing", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule